// File: doc/BRIEF.md
# Nibble-Programmed Reference and Feedback Divider Pair

This block holds two programmable frequency dividers whose ratios are written over a narrow 4-bit parallel bus. A host puts a nibble on the data lines and an address on the address lines, then raises a strobe. The addressed nibble slot follows the data for as long as the strobe stays high. Once the strobe drops, the slot keeps the last value it took. The slots build a 14-bit feedback ratio and a 12-bit reference ratio.

Both dividers run in one clock domain and advance only on their own enable input. The reference divider advances on reference-clock ticks and the feedback divider on input-frequency ticks. Each divider gives a single-cycle pulse per full division cycle. These pulses are the reference and feedback comparison signals for a downstream phase detector. A divider reloads its ratio only when it reaches terminal count, so rewriting a ratio never breaks a division already in progress.

Top module: `nibble_divider_pair`

## Requirements
- R1: Feedback ratio slots: address 0 carries ratio bits [3:0], address 1 bits [7:4], address 2 bits [11:8], and address 3 bits [13:12] from data bits [1:0]. Data bit 3 is the most significant bit of each nibble.
- R2: Reference ratio slots: address 4 carries ratio bits [3:0], address 5 bits [7:4] and address 6 bits [11:8].
- R3: A strobe at address 7 changes neither ratio.
- R4: While the strobe is high, the addressed slot takes the data value on every clock edge. After the strobe falls, the slot holds the value taken at the last edge with the strobe high, and later data changes have no effect.
- R5: Reset (rst_n low at a clock edge) clears both ratios and holds both pulse outputs low. Out of reset, with enables held high, each output pulses every 3 cycles.
- R6: ref_pulse is high for exactly one clock cycle per division cycle. With ref_en held high, its period in clocks equals the effective reference ratio.
- R7: fb_pulse is high for exactly one clock cycle per division cycle. With fb_en held high, its period in clocks equals the effective feedback ratio.
- R8: A programmed ratio of 0, 1 or 2 divides by 3. Ratios of 3 and above divide by the programmed value.
- R9: A ratio written during a division cycle takes effect only at the next reload. The cycle in progress completes with the old ratio.
- R10: A divider advances only on clock edges where its enable is high. With the enable held low, no pulse appears. With the enable high every other cycle, the period doubles.
- R11: The largest ratios, 16383 for feedback and 4095 for reference, divide correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 4 | Programming nibble, bit 3 most significant |
| bus_addr | input | 3 | Nibble slot select |
| bus_strobe | input | 1 | High: addressed slot follows bus_data |
| ref_en | input | 1 | Reference clock tick, advances reference divider |
| fb_en | input | 1 | Input frequency tick, advances feedback divider |
| ref_pulse | output | 1 | One-cycle pulse per reference division |
| fb_pulse | output | 1 | One-cycle pulse per feedback division |

## Verification
The checker relies on the strobe, address and data inputs being synchronous to clk and stable around each edge. It also relies on reset being held for more than one cycle, so the ratio registers have defined values before they are compared with their previous values. The bench drives every input on the falling clock edge and holds reset low for several cycles. Each bus write keeps the strobe high for at least one rising edge, with a settled address, so the slot contents are always a defined nibble.

// File: rtl/divider_pkg.sv
// Package: shared widths and the slot address layout for the divider pair.
// Assumes one nibble per slot; feedback slots start at address 0 and the
// reference slots follow directly after them.
package divider_pkg;
    localparam int NIB_W      = 4;
    localparam int ADDR_W     = 3;
    localparam int FB_W       = 14;
    localparam int REF_W      = 12;
    localparam int MIN_RATIO  = 3;
    localparam int FB_SLOTS   = (FB_W + NIB_W - 1) / NIB_W;
    localparam int REF_SLOTS  = (REF_W + NIB_W - 1) / NIB_W;
    localparam int FB_BASE    = 0;
    localparam int REF_BASE   = FB_BASE + FB_SLOTS;
endpackage

// File: rtl/nibble_slot_bank.sv
// Module: nibble_slot_bank
// Holds a ratio register assembled from nibble slots. Each bit sits in the
// slot (BASE + bit/NIB_W) at nibble position bit%NIB_W. While the strobe is
// high the addressed slot follows the bus every clock; otherwise it holds.
// Assumes bus inputs are synchronous to clk.
module nibble_slot_bank #(
    parameter int WIDTH  = 14,
    parameter int BASE   = 0,
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  bus_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    output logic [WIDTH-1:0]  ratio_q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int SLOT_ADDR = BASE + i / NIB_W;
        localparam int NIB_POS   = i % NIB_W;
        logic sel;
        // Slot decode for this bit.
        assign sel = bus_strobe && (bus_addr == ADDR_W'(SLOT_ADDR));
        // Transparent-while-strobed capture of one ratio bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ratio_q[i] <= 1'b0;
            else if (sel)
                ratio_q[i] <= bus_data[NIB_POS];
        end
    end
endmodule

// File: rtl/reload_divider.sv
// Module: reload_divider
// Down-counter that divides its enable stream by the programmed ratio,
// clamped to at least MIN. It reloads the ratio only at terminal count and
// emits a registered one-clock pulse on the edge that reloads.
// Assumes ratio may change at any time; it is sampled only at reload.
module reload_divider #(
    parameter int WIDTH = 14,
    parameter int MIN   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] ratio,
    output logic             pulse
);
    localparam logic [WIDTH-1:0] MIN_V = WIDTH'(MIN);
    localparam logic [WIDTH-1:0] ONE_V = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] ratio_eff;
    logic             at_end;

    // Clamp ratios below the minimum.
    assign ratio_eff = (ratio < MIN_V) ? MIN_V : ratio;
    // Terminal count reached on this enable.
    assign at_end    = (cnt_q <= ONE_V);

    // Count down on enable, reload at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= MIN_V;
        else if (en)
            cnt_q <= at_end ? ratio_eff : cnt_q - ONE_V;
    end

    // One-cycle output pulse per division cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= en && at_end;
    end
endmodule

// File: rtl/nibble_divider_pair.sv
// Module: nibble_divider_pair
// Top: two nibble slot banks (feedback and reference ratio) feeding two
// reloadable dividers. Unused addresses decode to no slot.
// Assumes all inputs are synchronous to clk; enables are single-cycle ticks.
module nibble_divider_pair
    import divider_pkg::*;
#(
    parameter int FB_WIDTH  = FB_W,
    parameter int REF_WIDTH = REF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  bus_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              ref_en,
    input  logic              fb_en,
    output logic              ref_pulse,
    output logic              fb_pulse
);
    localparam int FB_NSLOT = (FB_WIDTH + NIB_W - 1) / NIB_W;
    localparam int REF_ORG  = FB_BASE + FB_NSLOT;

    logic [FB_WIDTH-1:0]  fb_ratio;
    logic [REF_WIDTH-1:0] ref_ratio;

    nibble_slot_bank #(.WIDTH(FB_WIDTH), .BASE(FB_BASE), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_fb_bank (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .bus_strobe(bus_strobe), .ratio_q(fb_ratio)
    );

    nibble_slot_bank #(.WIDTH(REF_WIDTH), .BASE(REF_ORG), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_ref_bank (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .bus_strobe(bus_strobe), .ratio_q(ref_ratio)
    );

    reload_divider #(.WIDTH(FB_WIDTH), .MIN(MIN_RATIO)) u_fb_div (
        .clk(clk), .rst_n(rst_n), .en(fb_en), .ratio(fb_ratio), .pulse(fb_pulse)
    );

    reload_divider #(.WIDTH(REF_WIDTH), .MIN(MIN_RATIO)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .en(ref_en), .ratio(ref_ratio), .pulse(ref_pulse)
    );
endmodule

// File: rtl/nibble_divider_pair_chk.sv
// Module: nibble_divider_pair_chk
// Property checker bound to the top. Assumes inputs are synchronous and
// reset is held low for at least two edges.
module nibble_divider_pair_chk #(
    parameter int FB_WIDTH  = 14,
    parameter int REF_WIDTH = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           bus_addr,
    input logic                 bus_strobe,
    input logic                 ref_en,
    input logic                 fb_en,
    input logic                 ref_pulse,
    input logic                 fb_pulse,
    input logic [FB_WIDTH-1:0]  fb_ratio,
    input logic [REF_WIDTH-1:0] ref_ratio
);
    // R4 / R3: ratios move only after a strobe at a decoded address.
    assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_strobe) && ($past(bus_addr) != 3'd7)) |-> ($stable(fb_ratio) && $stable(ref_ratio)));

    // R6: reference pulse is one cycle wide.
    assert_ref_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R7: feedback pulse is one cycle wide.
    assert_fb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R10: a reference pulse follows an enabled edge.
    assert_ref_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_pulse) |-> $past(ref_en));

    // R10: a feedback pulse follows an enabled edge.
    assert_fb_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_pulse) |-> $past(fb_en));
endmodule

bind nibble_divider_pair nibble_divider_pair_chk #(.FB_WIDTH(FB_WIDTH), .REF_WIDTH(REF_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .ref_en(ref_en), .fb_en(fb_en), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .fb_ratio(fb_ratio), .ref_ratio(ref_ratio)
);

// File: tb/nibble_divider_pair_tb.sv
// Directed bench for nibble_divider_pair: drives on falling edges, samples
// on falling edges, measures output periods in clock cycles.
module nibble_divider_pair_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_data = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_strobe = 1'b0;
    logic       ref_en = 1'b0;
    logic       fb_en = 1'b0;
    logic       ref_pulse;
    logic       fb_pulse;
    logic       ref_toggle = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    nibble_divider_pair u_dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .bus_strobe(bus_strobe), .ref_en(ref_en), .fb_en(fb_en),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
    );

    // Optional alternating reference enable.
    always @(negedge clk) if (ref_toggle) ref_en <= ~ref_en;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(input int addr, input int nib);
        @(negedge clk);
        bus_addr = 3'(addr); bus_data = 4'(nib); bus_strobe = 1'b1;
        @(negedge clk);
        bus_strobe = 1'b0;
    endtask

    task automatic prog_fb(input int v);
        put(0, v & 15); put(1, (v >> 4) & 15); put(2, (v >> 8) & 15); put(3, (v >> 12) & 3);
    endtask

    task automatic prog_ref(input int v);
        put(4, v & 15); put(5, (v >> 4) & 15); put(6, (v >> 8) & 15);
    endtask

    function automatic bit sig(input bit is_ref);
        return is_ref ? ref_pulse : fb_pulse;
    endfunction

    // Waits at falling edges for the selected pulse; 0 on timeout.
    task automatic wait_pulse(input bit is_ref, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (sig(is_ref)) begin seen = 1'b1; break; end
        end
    endtask

    // Cycles from the current pulse to the next one; checks pulse width.
    task automatic period_from_here(input bit is_ref, input string tag, output int per);
        bit seen;
        @(negedge clk);
        check(!sig(is_ref), {tag, " pulse width"}, int'(sig(is_ref)), 0);
        per = 1;
        seen = 1'b0;
        for (int k = 0; k < 40000; k++) begin
            per++;
            @(negedge clk);
            if (sig(is_ref)) begin seen = 1'b1; break; end
        end
        if (!seen) per = -1;
    endtask

    // Steady-state period after a ratio change.
    task automatic measure(input bit is_ref, input string tag, input int exp);
        bit seen;
        int per;
        wait_pulse(is_ref, seen);
        wait_pulse(is_ref, seen);
        period_from_here(is_ref, tag, per);
        check(per == exp, tag, per, exp);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; ref_en = 1'b1; fb_en = 1'b1;
        repeat (4) @(negedge clk);
        check(!ref_pulse && !fb_pulse, "R5 reset outputs", int'(ref_pulse) + int'(fb_pulse), 0);
        rst_n = 1'b1;
        measure(1'b1, "R5 ref after reset", 3);
        measure(1'b0, "R5 fb after reset", 3);
    endtask

    task automatic test_fb_map();
        prog_fb(1234);
        measure(1'b0, "R1 R7 fb ratio 1234", 1234);
        prog_fb(5000);
        measure(1'b0, "R1 fb ratio 5000", 5000);
    endtask

    task automatic test_ref_map();
        prog_ref(3001);
        measure(1'b1, "R2 R6 ref ratio 3001", 3001);
    endtask

    task automatic test_addr7();
        prog_fb(11); prog_ref(13);
        put(7, 15);
        measure(1'b0, "R3 fb after addr 7", 11);
        measure(1'b1, "R3 ref after addr 7", 13);
    endtask

    task automatic test_strobe();
        prog_ref(0);
        @(negedge clk);
        bus_addr = 3'd4; bus_data = 4'd5; bus_strobe = 1'b1;
        @(negedge clk);
        bus_data = 4'd9;
        @(negedge clk);
        bus_strobe = 1'b0; bus_data = 4'd6;
        measure(1'b1, "R4 last strobed value", 9);
        bus_data = 4'd2;
        repeat (3) @(negedge clk);
        measure(1'b1, "R4 hold after fall", 9);
    endtask

    task automatic test_small();
        for (int v = 0; v < 3; v++) begin
            prog_fb(v);
            measure(1'b0, "R8 fb clamp", 3);
        end
        prog_ref(1);
        measure(1'b1, "R8 ref clamp", 3);
        prog_fb(4);
        measure(1'b0, "R8 fb ratio 4", 4);
    endtask

    task automatic test_reload();
        bit seen;
        int p1;
        int p2;
        prog_fb(20);
        wait_pulse(1'b0, seen);
        wait_pulse(1'b0, seen);
        fork
            prog_fb(7);
            period_from_here(1'b0, "R9 running cycle", p1);
        join
        check(p1 == 20, "R9 old ratio completes", p1, 20);
        period_from_here(1'b0, "R9 new cycle", p2);
        check(p2 == 7, "R9 new ratio at reload", p2, 7);
    endtask

    task automatic test_enable();
        bit any = 1'b0;
        prog_fb(5);
        @(negedge clk);
        fb_en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (fb_pulse) any = 1'b1;
        end
        check(!any, "R10 fb held off", int'(any), 0);
        fb_en = 1'b1;
        prog_ref(5);
        ref_toggle = 1'b1;
        measure(1'b1, "R10 ref half-rate", 10);
        ref_toggle = 1'b0;
        @(negedge clk);
        ref_en = 1'b1;
    endtask

    task automatic test_max();
        prog_fb(16383);
        measure(1'b0, "R11 fb max", 16383);
        prog_ref(4095);
        measure(1'b1, "R11 ref max", 4095);
    endtask

    initial begin
        test_reset();
        test_fb_map();
        test_ref_map();
        test_addr7();
        test_strobe();
        test_small();
        test_reload();
        test_enable();
        test_max();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule